// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a simple single-cycle register port and a behavioural model of a one-time-programmable fuse array. Software chooses a fuse word through an address field in the control register, and then starts one of three operations. It can read one word into a result register. It can program one word, which ORs new ones into the word, as long as a 16-bit unlock key sits in the control register. It can also reload, which copies every fuse word into a bank of readable shadow registers.

Every operation runs as three phases: a relax interval, a strobe pulse and a second relax interval. The relax count and the two strobe counts come from a software-written timing register, so the pulse widths follow whatever clock the block runs on. The controller raises BUSY for the whole operation. It raises a sticky ERROR flag when a request is rejected or fails.

The bus is a write strobe, a 12-bit byte address and 32-bit write data. Read data is combinational from the address. Registers: control `0x000`, its OR alias `0x004` and its mask-out alias `0x008`, timing `0x010`, program data `0x020`, read command `0x030`, read result `0x040`. Shadow word n sits at `0x400 + 0x10*n`. The control register holds the address in bits [5:0], BUSY in bit 8, ERROR in bit 9, RELOAD in bit 10 and the key in bits [31:16]. The timing register holds relax in [7:0], the read strobe count in [15:8] and the program strobe count in [31:16].

Top module: `otp_ctl`

## Requirements
- R1: After reset the control register reads 0, the timing register reads 0x000C0601, and the read result and every shadow word read 0.
- R2: A write to 0x004 ORs its address and key bits into the control register, and a write to 0x008 clears the address and key bits that are set in the written value.
- R3: Writing 1 in bit 0 of 0x030 reads the addressed word. BUSY stays high for exactly 2*(relax+1) + max(readstrobe - 2*relax + 1, 1) cycles, and the word is in 0x040 when BUSY falls.
- R4: Writing 0x020 while the key field holds 0x3E77 ORs the written data into the addressed fuse word. BUSY lasts 2*(relax+1) + max(progstrobe - 2*relax + 1, 1) cycles, and the key field reads 0 afterwards.
- R5: Writing 0x020 with any other key sets ERROR, leaves BUSY low and leaves the fuse word unchanged.
- R6: Writing 1 to bit 10 through 0x000 or 0x004 sets RELOAD and BUSY, copies every fuse word to its shadow register, and clears RELOAD together with BUSY.
- R7: ERROR is cleared only by writing 1 to bit 9 at 0x008. A direct write to 0x000 changes neither ERROR nor BUSY.
- R8: A read at an address of 16 or more writes 0xBADABADA to 0x040, sets ERROR and does not raise BUSY.
- R9: A program at an address of 16 or more sets ERROR, does not raise BUSY and leaves the key field as it was.
- R10: A read, program or reload request that arrives while BUSY is high, including in the last BUSY cycle, is ignored and sets ERROR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |

## Verification
Two functions can land in the same cycle: the sequencer finishing an operation, and a new request from the bus. The bench first measures the exact BUSY length of a read. On a second read it then times a new read command so that the command is sampled on the clock edge that ends BUSY. The result is judged at the ports. BUSY must be low after that edge, which shows no second operation started. ERROR must be high, which shows the request was counted as a collision and not taken as a fresh start.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int ADDR_W = 6;
    localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
    localparam logic [31:0] FAIL_WORD   = 32'hBADA_BADA;

    localparam logic [11:0] OFF_CTRL    = 12'h000;
    localparam logic [11:0] OFF_SET     = 12'h004;
    localparam logic [11:0] OFF_CLR     = 12'h008;
    localparam logic [11:0] OFF_TIMING  = 12'h010;
    localparam logic [11:0] OFF_PGM     = 12'h020;
    localparam logic [11:0] OFF_RDCMD   = 12'h030;
    localparam logic [11:0] OFF_RDRES   = 12'h040;

    localparam int BIT_BUSY   = 8;
    localparam int BIT_ERR    = 9;
    localparam int BIT_RELOAD = 10;

    typedef enum logic [1:0] {OP_READ, OP_PROG, OP_RELOAD} op_e;

    typedef struct packed {
        logic [15:0] pg_strobe;
        logic [7:0]  rd_strobe;
        logic [7:0]  relax;
    } timing_t;

    // Strobe high time: strobe count minus twice relax plus one, at least one cycle.
    function automatic logic [15:0] strobe_high(input logic [15:0] s, input logic [7:0] r);
        logic signed [18:0] v;
        v = $signed({3'b0, s}) - $signed({10'b0, r, 1'b0}) + 19'sd1;
        return (v < 19'sd1) ? 16'd1 : v[15:0];
    endfunction

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pg_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   pg_data,
    output logic [31:0]   rd_data
);

    logic [31:0] cells [WORDS];

    // Behavioural model: blank at reset, programming can only set bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (pg_en) begin
            cells[addr] <= cells[addr] | pg_data;
        end
    end

    assign rd_data = cells[addr];

endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  op_e           op_in,
    input  logic [AW-1:0] addr_in,
    input  logic [31:0]   data_in,
    input  timing_t       tmg,
    output logic          busy,
    output op_e           cur_op,
    output logic [AW-1:0] fa_addr,
    output logic          fa_pg,
    output logic [31:0]   fa_data,
    input  logic [31:0]   fa_rdata,
    output logic          rd_fire,
    output logic [31:0]   rd_word,
    output logic [AW-1:0] rd_idx,
    output logic          done
);

    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    typedef enum logic [1:0] {S_IDLE, S_PRE, S_STB, S_POST} state_e;

    state_e        st;
    logic [15:0]   cnt;
    logic [15:0]   hi;
    logic [7:0]    rlx;
    op_e           op;
    logic [AW-1:0] idx;
    logic [31:0]   data;
    logic          fire;
    logic          last;

    assign fire    = (st == S_STB) && (cnt == 16'd0);
    assign last    = (op != OP_RELOAD) || (idx == LAST_IDX);
    assign busy    = (st != S_IDLE);
    assign cur_op  = op;
    assign fa_addr = idx;
    assign fa_data = data;
    assign fa_pg   = fire && (op == OP_PROG);
    assign rd_fire = fire && (op != OP_PROG);
    assign rd_word = fa_rdata;
    assign rd_idx  = idx;
    assign done    = (st == S_POST) && (cnt == 16'd0) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cnt  <= '0;
            hi   <= 16'd1;
            rlx  <= '0;
            op   <= OP_READ;
            idx  <= '0;
            data <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    op   <= op_in;
                    idx  <= (op_in == OP_RELOAD) ? '0 : addr_in;
                    data <= data_in;
                    rlx  <= tmg.relax;
                    hi   <= strobe_high((op_in == OP_PROG) ? tmg.pg_strobe : {8'b0, tmg.rd_strobe},
                                        tmg.relax);
                    cnt  <= {8'b0, tmg.relax};
                    st   <= S_PRE;
                end
                S_PRE: if (cnt == 16'd0) begin
                    st  <= S_STB;
                    cnt <= hi - 16'd1;
                end else cnt <= cnt - 16'd1;
                S_STB: if (cnt == 16'd0) begin
                    st  <= S_POST;
                    cnt <= {8'b0, rlx};
                end else cnt <= cnt - 16'd1;
                S_POST: if (cnt == 16'd0) begin
                    if (last) st <= S_IDLE;
                    else begin
                        idx <= idx + 1'b1;
                        cnt <= {8'b0, rlx};
                        st  <= S_PRE;
                    end
                end else cnt <= cnt - 16'd1;
                default: st <= S_IDLE;
            endcase
        end
    end

    // The register block must never launch an operation on a busy sequencer.
    assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> (st == S_IDLE));

    // The final phase is reached only after the fuse word was touched.
    assert_done_after_fire_R3: assert property (@(posedge clk) disable iff (rst)
        fire |=> (st == S_POST));

endmodule

// File: rtl/otp_ctl.sv
module otp_ctl
    import otp_pkg::*;
#(
    parameter int WORDS = 16,
    parameter logic [31:0] TIMING_RST = 32'h000C_0601,
    localparam int AW = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(WORDS);

    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       key_q;
    logic              err_q;
    logic              reload_q;
    timing_t           tmg_q;
    logic [31:0]       rdres_q;
    logic [31:0]       shadow [WORDS];

    logic wr_ctrl, wr_set, wr_clr, wr_tmg, wr_pgm, wr_rdc;
    logic reload_req, read_req, prog_req, any_req;
    logic addr_ok, key_ok, start, err_set, read_fail;
    op_e  start_op;

    logic          busy, fa_pg, rd_fire, done;
    op_e           cur_op;
    logic [AW-1:0] fa_addr, rd_idx;
    logic [31:0]   fa_data, fa_rdata, rd_word;

    assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
    assign wr_set  = bus_wr && (bus_addr == OFF_SET);
    assign wr_clr  = bus_wr && (bus_addr == OFF_CLR);
    assign wr_tmg  = bus_wr && (bus_addr == OFF_TIMING);
    assign wr_pgm  = bus_wr && (bus_addr == OFF_PGM);
    assign wr_rdc  = bus_wr && (bus_addr == OFF_RDCMD);

    assign reload_req = (wr_ctrl || wr_set) && bus_wdata[BIT_RELOAD];
    assign read_req   = wr_rdc && bus_wdata[0];
    assign prog_req   = wr_pgm;
    assign any_req    = reload_req || read_req || prog_req;

    assign addr_ok   = ({1'b0, addr_q} < LIMIT);
    assign key_ok    = (key_q == UNLOCK_KEY);
    assign read_fail = read_req && !busy && !addr_ok;
    assign start     = !busy && (reload_req || (read_req && addr_ok) ||
                                 (prog_req && key_ok && addr_ok));
    assign start_op  = reload_req ? OP_RELOAD : (prog_req ? OP_PROG : OP_READ);
    assign err_set   = any_req && (busy || read_fail ||
                                   (prog_req && (!key_ok || !addr_ok)));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            key_q    <= '0;
            err_q    <= 1'b0;
            reload_q <= 1'b0;
            tmg_q    <= timing_t'(TIMING_RST);
            rdres_q  <= '0;
            for (int i = 0; i < WORDS; i++) shadow[i] <= '0;
        end else begin
            if (wr_ctrl) begin
                addr_q <= bus_wdata[ADDR_W-1:0];
                key_q  <= bus_wdata[31:16];
            end else if (wr_set) begin
                addr_q <= addr_q | bus_wdata[ADDR_W-1:0];
                key_q  <= key_q | bus_wdata[31:16];
            end else if (wr_clr) begin
                addr_q <= addr_q & ~bus_wdata[ADDR_W-1:0];
                key_q  <= key_q & ~bus_wdata[31:16];
            end
            if (done && cur_op == OP_PROG) key_q <= '0;

            if (err_set) err_q <= 1'b1;
            else if (wr_clr && bus_wdata[BIT_ERR]) err_q <= 1'b0;

            if (start && start_op == OP_RELOAD) reload_q <= 1'b1;
            else if (done && cur_op == OP_RELOAD) reload_q <= 1'b0;

            if (wr_tmg) tmg_q <= timing_t'(bus_wdata);

            if (read_fail) rdres_q <= FAIL_WORD;
            else if (rd_fire && cur_op == OP_READ) rdres_q <= rd_word;

            if (rd_fire && cur_op == OP_RELOAD) shadow[rd_idx] <= rd_word;
        end
    end

    otp_seq #(.WORDS(WORDS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .op_in(start_op),
        .addr_in(addr_q[AW-1:0]), .data_in(bus_wdata), .tmg(tmg_q),
        .busy(busy), .cur_op(cur_op), .fa_addr(fa_addr), .fa_pg(fa_pg),
        .fa_data(fa_data), .fa_rdata(fa_rdata), .rd_fire(rd_fire),
        .rd_word(rd_word), .rd_idx(rd_idx), .done(done)
    );

    otp_fuse_array #(.WORDS(WORDS)) u_array (
        .clk(clk), .rst(rst), .pg_en(fa_pg), .addr(fa_addr),
        .pg_data(fa_data), .rd_data(fa_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:10] == 2'b01) begin
            if (bus_addr[3:0] == 4'd0 && ({1'b0, bus_addr[9:4]} < LIMIT))
                bus_rdata = shadow[bus_addr[4 +: AW]];
        end else begin
            case (bus_addr)
                OFF_CTRL:   bus_rdata = {key_q, 5'b0, reload_q, err_q, busy, 2'b0, addr_q};
                OFF_TIMING: bus_rdata = tmg_q;
                OFF_RDRES:  bus_rdata = rdres_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(wr_clr && bus_wdata[BIT_ERR])) |=> err_q);

    assert_busy_reject_R10: assert property (@(posedge clk) disable iff (rst)
        (any_req && busy) |=> err_q);

    assert_key_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == OP_PROG) |=> (key_q == 16'd0));

    assert_reload_with_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(reload_q) |-> !busy);

    assert_fail_no_busy_R8: assert property (@(posedge clk) disable iff (rst)
        read_fail |=> !busy);

endmodule

// File: tb/otp_ctl_test.sv
module otp_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_W = 2'd0, K_C = 2'd1, K_P = 2'd2;
    localparam int NV = 53;

    // {kind, address, data/expected, requirement number}
    localparam logic [49:0] VECS [NV] = '{
        {K_W, 12'h010, 32'h0014_0A02, 4'd3},
        {K_C, 12'h010, 32'h0014_0A02, 4'd3},
        {K_W, 12'h000, 32'h3E77_0003, 4'd4},
        {K_W, 12'h020, 32'h0000_00F0, 4'd4},
        {K_P, 12'h000, 32'h0,         4'd4},
        {K_C, 12'h000, 32'h0000_0003, 4'd4},  // R4 key gone
        {K_W, 12'h030, 32'h0000_0001, 4'd3},
        {K_P, 12'h000, 32'h0,         4'd3},
        {K_C, 12'h040, 32'h0000_00F0, 4'd3},  // R3 word read back
        {K_W, 12'h000, 32'h3E77_0003, 4'd4},
        {K_W, 12'h020, 32'h0F00_000F, 4'd4},
        {K_P, 12'h000, 32'h0,         4'd4},
        {K_W, 12'h030, 32'h0000_0001, 4'd4},
        {K_P, 12'h000, 32'h0,         4'd4},
        {K_C, 12'h040, 32'h0F00_00FF, 4'd4},  // R4 OR accumulation
        {K_W, 12'h000, 32'h1234_0003, 4'd5},
        {K_W, 12'h020, 32'hFFFF_FFFF, 4'd5},
        {K_C, 12'h000, 32'h1234_0203, 4'd5},  // R5 error, no busy
        {K_W, 12'h000, 32'h1234_0003, 4'd7},
        {K_C, 12'h000, 32'h1234_0203, 4'd7},  // R7 direct write keeps error
        {K_W, 12'h008, 32'h0000_0200, 4'd7},
        {K_C, 12'h000, 32'h1234_0003, 4'd7},  // R7 cleared via alias
        {K_W, 12'h030, 32'h0000_0001, 4'd5},
        {K_P, 12'h000, 32'h0,         4'd5},
        {K_C, 12'h040, 32'h0F00_00FF, 4'd5},  // R5 fuse unchanged
        {K_W, 12'h008, 32'hFFFF_003F, 4'd2},
        {K_C, 12'h000, 32'h0000_0000, 4'd2},  // R2
        {K_W, 12'h004, 32'h0000_0005, 4'd2},
        {K_W, 12'h004, 32'h0000_0002, 4'd2},
        {K_C, 12'h000, 32'h0000_0007, 4'd2},  // R2 OR alias
        {K_W, 12'h008, 32'h0000_0001, 4'd2},
        {K_C, 12'h000, 32'h0000_0006, 4'd2},  // R2 mask alias
        {K_W, 12'h004, 32'h3E77_0000, 4'd4},
        {K_W, 12'h020, 32'h0000_00A5, 4'd4},
        {K_P, 12'h000, 32'h0,         4'd4},
        {K_W, 12'h004, 32'h0000_0400, 4'd6},
        {K_C, 12'h000, 32'h0000_0506, 4'd6},  // R6 reload+busy
        {K_P, 12'h000, 32'h0,         4'd6},
        {K_C, 12'h000, 32'h0000_0006, 4'd6},  // R6 self-clear
        {K_C, 12'h430, 32'h0F00_00FF, 4'd6},
        {K_C, 12'h460, 32'h0000_00A5, 4'd6},
        {K_C, 12'h400, 32'h0000_0000, 4'd6},
        {K_W, 12'h000, 32'h0000_0020, 4'd8},
        {K_W, 12'h030, 32'h0000_0001, 4'd8},
        {K_C, 12'h000, 32'h0000_0220, 4'd8},  // R8
        {K_C, 12'h040, 32'hBADA_BADA, 4'd8},
        {K_W, 12'h008, 32'h0000_0200, 4'd9},
        {K_W, 12'h000, 32'h3E77_0011, 4'd9},
        {K_W, 12'h020, 32'h0000_0001, 4'd9},
        {K_C, 12'h000, 32'h3E77_0211, 4'd9},  // R9
        {K_W, 12'h008, 32'hFFFF_023F, 4'd7},
        {K_W, 12'h000, 32'h0000_0300, 4'd7},
        {K_C, 12'h000, 32'h0000_0000, 4'd7}   // R7 busy/error not writable
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    otp_ctl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_at(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        read_at(12'h000, v);
        while (v[8]) begin
            @(negedge clk);
            read_at(12'h000, v);
        end
    endtask

    // Issue a write that starts an operation, return the number of busy cycles.
    task automatic run_count(input logic [11:0] a, input logic [31:0] d, output int n);
        logic [31:0] v;
        do_write(a, d);
        n = 0;
        read_at(12'h000, v);
        while (v[8]) begin
            n++;
            @(negedge clk);
            read_at(12'h000, v);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        read_at(12'h000, v); check("R1", v, 32'h0);
        read_at(12'h010, v); check("R1", v, 32'h000C_0601);
        read_at(12'h040, v); check("R1", v, 32'h0);
        read_at(12'h4F0, v); check("R1", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [49:0] e;
            string tag;
            e = VECS[i];
            tag = $sformatf("R%0d vec%0d", e[3:0], i);
            case (e[49:48])
                K_W: do_write(e[47:36], e[35:4]);
                K_C: begin read_at(e[47:36], v); check(tag, v, e[35:4]); end
                default: wait_idle();
            endcase
        end

        // R3 exact read busy length: relax 2, read strobe 10 -> 6 + 7
        do_write(12'h000, 32'h0000_0003);
        run_count(12'h030, 32'h1, n);
        check("R3 busy cycles", 32'(n), 32'd13);
        read_at(12'h040, v); check("R3", v, 32'h0F00_00FF);

        // R4 exact program busy length: program strobe 20 -> 6 + 17
        do_write(12'h004, 32'h3E77_0000);
        run_count(12'h020, 32'h0, n);
        check("R4 busy cycles", 32'(n), 32'd23);
        read_at(12'h000, v); check("R4", v, 32'h0000_0003);

        // R10 request in mid-operation
        do_write(12'h030, 32'h1);
        do_write(12'h004, 32'h0000_0400);
        read_at(12'h000, v); check("R10 mid", v, 32'h0000_0303);
        wait_idle();
        read_at(12'h000, v); check("R10 mid", v, 32'h0000_0203);
        do_write(12'h008, 32'h0000_0200);

        // R10 request sampled on the edge that ends BUSY
        do_write(12'h030, 32'h1);
        n = 1;
        while (n < 13) begin
            @(negedge clk);
            n++;
        end
        read_at(12'h000, v); check("R10 last busy", v, 32'h0000_0103);
        bus_wr = 1'b1; bus_addr = 12'h030; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        read_at(12'h000, v); check("R10 edge", v, 32'h0000_0203);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule